// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a synchronous model of the command front end and the operation sequencer of a NOR flash device. A host issues single-cycle bus writes, each carrying an address and a command or data byte, and single-cycle read strobes. The controller decodes the writes into read-mode selections and into multi-write sequences: page program, block erase, lock-bit program, erase of every unlocked block, suspend/resume and status clear. It drives a busy output while an operation runs.

The storage is a small behavioural byte array split into equal blocks, each with a lock bit. Program and erase times are not modelled as physical pulses. A parameterised cycle counter stands in for them, and the array is updated in the cycle the counter expires. An 8-bit status byte reports readiness, suspension and three sticky error flags. Write protection for locked blocks depends on a protect-release input and an override input.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While reset is active and after its release, busy is 0, the read mode is array, the status byte is 80h, every array byte reads FFh and every block lock bit is 1 (unlocked).
- R2: Writing FFh, 90h, 70h or 71h selects array, identifier, status or lock-status reads. A read strobe loads rdata at the next clock edge from the selected source, and rdata holds its value between strobes.
- R3: In identifier mode, a read with addr bit 0 = 0 returns 07h. With addr bit 0 = 1 it returns 85h when TOP_BOOT = 1 and 86h otherwise.
- R4: The status byte has these fields: bit 7 = ready (1) or busy (0), bit 6 = suspended, bit 5 = erase error, bit 4 = program error, bit 3 = over-program error. Bits 2:0 always read 0.
- R5: After 20h (block erase), 77h (lock-bit program) or A7h (erase all), the next write must be D0h. Any other byte cancels the sequence, starts nothing, and sets bits 5 and 4.
- R6: After 41h, 128 data writes follow, and addr[6:0] of write n must equal n. The page is the one addressed by the first data write. A write out of order cancels the load and sets bits 5 and 4. Programming ANDs each byte into the array.
- R7: busy rises in the cycle after the final page word or the D0h confirm. It stays high for PROG_CYC cycles (page and lock-bit program) or ERASE_CYC cycles (block erase and erase all), minus any time spent suspended.
- R8: While busy is high, every write other than B0h has no effect. Every read returns the status byte, whatever the read mode.
- R9: B0h written while busy suspends the operation: busy falls, and bits 7 and 6 read 1. While suspended, the mode commands take effect and the array can be read. D0h resumes the operation, busy rises again and bit 6 clears.
- R10: If a block's lock bit is 0 and both wr_protect and lock_override are low, a program to it sets bit 4 and an erase of it sets bit 5, and its contents do not change. If either input is high, the operation runs, and an erase sets the block's lock bit back to 1.
- R11: In lock-status mode, a read returns the lock bit of the addressed block on bit 6, with all other bits 0. 77h followed by D0h at a block address clears that block's lock bit.
- R12: A7h followed by D0h erases every block that is unlocked or released by wr_protect or lock_override, and leaves every other block unchanged.
- R13: Writing 50h while idle clears bits 5, 4 and 3. Otherwise those bits stay set once set.
- R14: When a completed page program asked for a 1 in a bit whose cell already held 0, bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; loads rdata at the edge |
| addr | input | ADDR_W | Byte address; top BLK_W bits select the block |
| wdata | input | 8 | Command or data byte |
| wr_protect | input | 1 | High releases the protection of locked blocks |
| lock_override | input | 1 | High releases the protection of locked blocks |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | Operation running and not suspended |

## Verification
The bench aims at the sequence edges. It sends a non-confirm byte after a two-write command, which a wrong design would treat as harmless or would launch anyway. It sends a page word out of order, which a design without order checking would program into the wrong cell. It writes clear and mode commands during busy, which a leaky decoder would act on and so lose sticky errors or change what reads return. It suspends and resumes an erase and checks the exact remaining busy length, so a counter that kept running or restarted while suspended shows up as a wrong cycle count. It also reprograms pages to provoke over-program errors, and it operates on locked blocks with each release input, to catch protection that ignores one input or fails to restore the lock bit.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_IDENT = 8'h90;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;
  localparam logic [7:0] CMD_PAGE_PGM   = 8'h41;
  localparam logic [7:0] CMD_BLK_ERASE  = 8'h20;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_READ_LOCK  = 8'h71;
  localparam logic [7:0] CMD_LOCK_PGM   = 8'h77;
  localparam logic [7:0] CMD_ERASE_ALL  = 8'hA7;

  localparam logic [7:0] MAKER_ID      = 8'h07;
  localparam logic [7:0] DEV_ID_TOP    = 8'h85;
  localparam logic [7:0] DEV_ID_BOTTOM = 8'h86;

  typedef enum logic [1:0] {
    RM_ARRAY,
    RM_IDENT,
    RM_STATUS,
    RM_LOCK
  } rd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ERASE_CF,
    SQ_LOCK_CF,
    SQ_ALL_CF,
    SQ_PAGE
  } seq_e;

  typedef enum logic [1:0] {
    OP_PROG,
    OP_ERASE,
    OP_LOCK,
    OP_ERASE_ALL
  } op_e;

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dur,
  input  logic             susp_req,
  input  logic             resume_req,
  output logic             active,
  output logic             suspended,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             sus_q, sus_d;

  assign active    = act_q;
  assign suspended = sus_q;
  assign done      = act_q & ~sus_q & (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    sus_d = sus_q;
    if (start) begin
      act_d = 1'b1;
      sus_d = 1'b0;
      cnt_d = dur;
    end else if (act_q) begin
      if (done) begin
        act_d = 1'b0;
        sus_d = 1'b0;
      end else if (sus_q) begin
        if (resume_req) sus_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
        if (susp_req) sus_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      sus_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      sus_q <= sus_d;
    end
  end

endmodule

// File: rtl/flash_cell_store.sv
module flash_cell_store #(
  parameter int ADDR_W = 10,
  parameter int BLK_W  = 2,
  parameter int PAGE_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_data,
  input  logic                     pgm_commit,
  input  logic [ADDR_W-PAGE_W-1:0] pgm_base,
  input  logic                     ers_commit,
  input  logic                     all_commit,
  input  logic                     all_open,
  input  logic                     lock_commit,
  input  logic [BLK_W-1:0]         tgt_blk,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic [(1<<BLK_W)-1:0]    lock_bits,
  output logic                     over_pgm
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int NBLK       = 1 << BLK_W;
  localparam int OFF_W      = ADDR_W - BLK_W;
  localparam int BLK_SIZE   = 1 << OFF_W;
  localparam int PAGE_WORDS = 1 << PAGE_W;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE_WORDS];
  logic [NBLK-1:0] lock_q, lock_d;

  assign rd_data   = mem[rd_addr];
  assign lock_bits = lock_q;

  always_comb begin
    over_pgm = 1'b0;
    for (int i = 0; i < PAGE_WORDS; i++) begin
      if (|(pbuf[i] & ~mem[{pgm_base, PAGE_W'(i)}])) over_pgm = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (pgm_commit) begin
        for (int i = 0; i < PAGE_WORDS; i++)
          mem[{pgm_base, PAGE_W'(i)}] <= mem[{pgm_base, PAGE_W'(i)}] & pbuf[i];
      end
      if (ers_commit) begin
        for (int j = 0; j < BLK_SIZE; j++) mem[{tgt_blk, OFF_W'(j)}] <= 8'hFF;
      end
      if (all_commit) begin
        for (int b = 0; b < NBLK; b++) begin
          if (lock_q[b] | all_open) begin
            for (int j = 0; j < BLK_SIZE; j++) mem[{BLK_W'(b), OFF_W'(j)}] <= 8'hFF;
          end
        end
      end
    end
  end

  always_comb begin
    lock_d = lock_q;
    if (lock_commit) lock_d[tgt_blk] = 1'b0;
    if (ers_commit)  lock_d[tgt_blk] = 1'b1;
    if (all_commit) begin
      for (int b = 0; b < NBLK; b++)
        if (all_open) lock_d[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '1;
    else        lock_q <= lock_d;
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BLK_W     = 2,
  parameter int PAGE_W    = 7,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 200,
  parameter int CNT_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               wdata,
  input  logic                     wr_protect,
  input  logic                     lock_override,
  input  logic [(1<<BLK_W)-1:0]    lock_bits,
  input  logic                     over_pgm,
  input  logic                     active,
  input  logic                     suspended,
  input  logic                     done,
  output rd_mode_e                 mode,
  output logic                     err_erase,
  output logic                     err_pgm,
  output logic                     err_over,
  output logic                     start,
  output logic [CNT_W-1:0]         dur,
  output logic                     susp_req,
  output logic                     resume_req,
  output logic                     buf_we,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic                     pgm_commit,
  output logic [ADDR_W-PAGE_W-1:0] pgm_base,
  output logic                     ers_commit,
  output logic                     all_commit,
  output logic                     all_open,
  output logic                     lock_commit,
  output logic [BLK_W-1:0]         tgt_blk
);

  localparam int PBASE_W = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] LAST_WORD = '1;

  rd_mode_e           mode_q, mode_d;
  seq_e               seq_q, seq_d;
  op_e                op_q, op_d;
  logic [PAGE_W-1:0]  pcnt_q, pcnt_d;
  logic [PBASE_W-1:0] base_q, base_d;
  logic [BLK_W-1:0]   blk_q, blk_d;
  logic               open_q, open_d;
  logic               ee_q, ee_d, pe_q, pe_d, oe_q, oe_d;

  logic [BLK_W-1:0] wr_blk;
  logic [BLK_W-1:0] page_blk;
  logic             released;
  logic             running;

  assign wr_blk   = addr[ADDR_W-1 -: BLK_W];
  assign page_blk = base_q[PBASE_W-1 -: BLK_W];
  assign released = wr_protect | lock_override;
  assign running  = active & ~suspended;

  assign mode        = mode_q;
  assign err_erase   = ee_q;
  assign err_pgm     = pe_q;
  assign err_over    = oe_q;
  assign buf_idx     = pcnt_q;
  assign pgm_base    = base_q;
  assign tgt_blk     = blk_q;
  assign all_open    = open_q;
  assign pgm_commit  = done & (op_q == OP_PROG);
  assign ers_commit  = done & (op_q == OP_ERASE);
  assign all_commit  = done & (op_q == OP_ERASE_ALL);
  assign lock_commit = done & (op_q == OP_LOCK);

  always_comb begin
    mode_d     = mode_q;
    seq_d      = seq_q;
    op_d       = op_q;
    pcnt_d     = pcnt_q;
    base_d     = base_q;
    blk_d      = blk_q;
    open_d     = open_q;
    ee_d       = ee_q;
    pe_d       = pe_q;
    oe_d       = oe_q;
    start      = 1'b0;
    dur        = CNT_W'(PROG_CYC);
    susp_req   = 1'b0;
    resume_req = 1'b0;
    buf_we     = 1'b0;

    if (pgm_commit && over_pgm) oe_d = 1'b1;

    if (wr_en) begin
      if (running) begin
        if (wdata == CMD_SUSPEND) susp_req = 1'b1;
      end else if (suspended) begin
        case (wdata)
          CMD_READ_ARRAY: mode_d = RM_ARRAY;
          CMD_READ_IDENT: mode_d = RM_IDENT;
          CMD_READ_STAT:  mode_d = RM_STATUS;
          CMD_READ_LOCK:  mode_d = RM_LOCK;
          CMD_CONFIRM:    resume_req = 1'b1;
          default: ;
        endcase
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            case (wdata)
              CMD_READ_ARRAY: mode_d = RM_ARRAY;
              CMD_READ_IDENT: mode_d = RM_IDENT;
              CMD_READ_STAT:  mode_d = RM_STATUS;
              CMD_READ_LOCK:  mode_d = RM_LOCK;
              CMD_CLEAR_STAT: begin
                ee_d = 1'b0;
                pe_d = 1'b0;
                oe_d = 1'b0;
              end
              CMD_PAGE_PGM: begin
                seq_d  = SQ_PAGE;
                pcnt_d = '0;
                mode_d = RM_STATUS;
              end
              CMD_BLK_ERASE: begin
                seq_d  = SQ_ERASE_CF;
                mode_d = RM_STATUS;
              end
              CMD_LOCK_PGM: begin
                seq_d  = SQ_LOCK_CF;
                mode_d = RM_STATUS;
              end
              CMD_ERASE_ALL: begin
                seq_d  = SQ_ALL_CF;
                mode_d = RM_STATUS;
              end
              default: ;
            endcase
          end
          SQ_ERASE_CF, SQ_LOCK_CF, SQ_ALL_CF: begin
            seq_d  = SQ_IDLE;
            mode_d = RM_STATUS;
            if (wdata != CMD_CONFIRM) begin
              ee_d = 1'b1;
              pe_d = 1'b1;
            end else if (seq_q == SQ_ERASE_CF) begin
              if (lock_bits[wr_blk] | released) begin
                start = 1'b1;
                dur   = CNT_W'(ERASE_CYC);
                op_d  = OP_ERASE;
                blk_d = wr_blk;
              end else begin
                ee_d = 1'b1;
              end
            end else if (seq_q == SQ_LOCK_CF) begin
              start = 1'b1;
              dur   = CNT_W'(PROG_CYC);
              op_d  = OP_LOCK;
              blk_d = wr_blk;
            end else begin
              start  = 1'b1;
              dur    = CNT_W'(ERASE_CYC);
              op_d   = OP_ERASE_ALL;
              open_d = released;
            end
          end
          SQ_PAGE: begin
            if (addr[PAGE_W-1:0] != pcnt_q) begin
              seq_d = SQ_IDLE;
              ee_d  = 1'b1;
              pe_d  = 1'b1;
            end else begin
              buf_we = 1'b1;
              if (pcnt_q == '0) base_d = addr[ADDR_W-1:PAGE_W];
              if (pcnt_q == LAST_WORD) begin
                seq_d = SQ_IDLE;
                if (lock_bits[page_blk] | released) begin
                  start = 1'b1;
                  dur   = CNT_W'(PROG_CYC);
                  op_d  = OP_PROG;
                end else begin
                  pe_d = 1'b1;
                end
              end else begin
                pcnt_d = pcnt_q + PAGE_W'(1);
              end
            end
          end
          default: seq_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_ARRAY;
      seq_q  <= SQ_IDLE;
      op_q   <= OP_PROG;
      pcnt_q <= '0;
      base_q <= '0;
      blk_q  <= '0;
      open_q <= 1'b0;
      ee_q   <= 1'b0;
      pe_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      seq_q  <= seq_d;
      op_q   <= op_d;
      pcnt_q <= pcnt_d;
      base_q <= base_d;
      blk_q  <= blk_d;
      open_q <= open_d;
      ee_q   <= ee_d;
      pe_q   <= pe_d;
      oe_q   <= oe_d;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BLK_W     = 2,
  parameter int PAGE_W    = 7,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 200,
  parameter bit TOP_BOOT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_protect,
  input  logic              lock_override,
  output logic [7:0]        rdata,
  output logic              busy
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int NBLK    = 1 << BLK_W;
  localparam int PBASE_W = ADDR_W - PAGE_W;
  localparam logic [7:0] DEV_ID = TOP_BOOT ? DEV_ID_TOP : DEV_ID_BOTTOM;

  rd_mode_e           mode;
  logic               err_erase, err_pgm, err_over;
  logic               start, susp_req, resume_req;
  logic [CNT_W-1:0]   dur;
  logic               op_active, op_susp, op_done;
  logic               buf_we;
  logic [PAGE_W-1:0]  buf_idx;
  logic               pgm_commit, ers_commit, all_commit, all_open, lock_commit;
  logic [PBASE_W-1:0] pgm_base;
  logic [BLK_W-1:0]   tgt_blk;
  logic [7:0]         cell_rd;
  logic [NBLK-1:0]    lock_bits;
  logic               over_pgm;
  logic [7:0]         status;
  logic [7:0]         rd_src;
  logic [7:0]         rdata_q, rdata_d;

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wr_protect(wr_protect), .lock_override(lock_override),
    .lock_bits(lock_bits), .over_pgm(over_pgm),
    .active(op_active), .suspended(op_susp), .done(op_done),
    .mode(mode), .err_erase(err_erase), .err_pgm(err_pgm), .err_over(err_over),
    .start(start), .dur(dur), .susp_req(susp_req), .resume_req(resume_req),
    .buf_we(buf_we), .buf_idx(buf_idx), .pgm_commit(pgm_commit),
    .pgm_base(pgm_base), .ers_commit(ers_commit), .all_commit(all_commit),
    .all_open(all_open), .lock_commit(lock_commit), .tgt_blk(tgt_blk)
  );

  flash_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .dur(dur),
    .susp_req(susp_req), .resume_req(resume_req),
    .active(op_active), .suspended(op_susp), .done(op_done)
  );

  flash_cell_store #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_data(wdata), .pgm_commit(pgm_commit), .pgm_base(pgm_base),
    .ers_commit(ers_commit), .all_commit(all_commit), .all_open(all_open),
    .lock_commit(lock_commit), .tgt_blk(tgt_blk), .rd_addr(addr),
    .rd_data(cell_rd), .lock_bits(lock_bits), .over_pgm(over_pgm)
  );

  assign busy   = op_active & ~op_susp;
  assign status = {~busy, op_susp, err_erase, err_pgm, err_over, 3'b000};

  always_comb begin
    if (busy) begin
      rd_src = status;
    end else begin
      case (mode)
        RM_ARRAY:  rd_src = cell_rd;
        RM_IDENT:  rd_src = addr[0] ? DEV_ID : MAKER_ID;
        RM_STATUS: rd_src = status;
        default:   rd_src = {1'b0, lock_bits[addr[ADDR_W-1 -: BLK_W]], 6'b000000};
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 8'h00;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic       busy,
  input logic [1:0] rd_hi,
  input logic [2:0] rd_lo,
  input logic       op_active,
  input logic       op_done
);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R8
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_hi == 2'b00 && rd_lo == 3'b000));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_en && wdata == 8'hB0)) |=> (busy || !op_active));

  // R9
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wdata == 8'hB0 && !op_done) |=> (!busy && op_active));

  // R9
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_active && wr_en && wdata == 8'hD0) |=> busy);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .busy(busy), .rd_hi(rdata[7:6]), .rd_lo(rdata[2:0]),
  .op_active(op_active), .op_done(op_done)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;

  localparam int PCYC = 12;
  localparam int ECYC = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [9:0] addr;
  logic [7:0] wdata;
  logic       wp, ovr;
  logic [7:0] rdata;
  logic       busy;

  int total = 0;
  int bad   = 0;

  logic [7:0] m  [1024];
  logic       lk [4];
  logic [7:0] pd [128];
  bit         es, ps, bs;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYC(PCYC), .ERASE_CYC(ECYC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wr_protect(wp), .lock_override(ovr),
    .rdata(rdata), .busy(busy)
  );

  function automatic logic [7:0] stat_exp(input bit rdy, input bit sus);
    return {rdy, sus, es, ps, bs, 3'b000};
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = 10'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    rd_en = 1'b1; addr = 10'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic load_page(input int blk, input int pg);
    wr(0, 8'h41);
    for (int i = 0; i < 128; i++) begin
      pd[i] = 8'($urandom);
      wr(blk*256 + pg*128 + i, pd[i]);
    end
  endtask

  task automatic apply_page(input int blk, input int pg);
    bit ov = 0;
    for (int i = 0; i < 128; i++) begin
      int a = blk*256 + pg*128 + i;
      if ((pd[i] & ~m[a]) != 0) ov = 1;
      m[a] = m[a] & pd[i];
    end
    if (ov) bs = 1;
  endtask

  task automatic prog_page(input int blk, input int pg, input string tag);
    int n;
    logic [7:0] v;
    load_page(blk, pg);
    if (!lk[blk] && !wp && !ovr) begin
      ps = 1;
      chk({tag, " R10 rejected program stays idle"}, busy, 0);
    end else begin
      busy_len(n);
      chk({tag, " R7 program busy length"}, n, PCYC);
      apply_page(blk, pg);
    end
    rd(0, v);
    chk({tag, " R4 R14 status after program"}, v, stat_exp(1, 0));
  endtask

  task automatic erase_blk(input int blk, input string tag);
    int n;
    logic [7:0] v;
    wr(0, 8'h20);
    wr(blk*256 + 3, 8'hD0);
    if (!lk[blk] && !wp && !ovr) begin
      es = 1;
      chk({tag, " R10 rejected erase stays idle"}, busy, 0);
    end else begin
      busy_len(n);
      chk({tag, " R7 erase busy length"}, n, ECYC);
      for (int j = 0; j < 256; j++) m[blk*256 + j] = 8'hFF;
      lk[blk] = 1;
    end
    rd(0, v);
    chk({tag, " R4 status after erase"}, v, stat_exp(1, 0));
  endtask

  task automatic lock_blk(input int blk);
    int n;
    wr(0, 8'h77);
    wr(blk*256 + 9, 8'hD0);
    busy_len(n);
    chk("R11 lock program busy length", n, PCYC);
    lk[blk] = 0;
  endtask

  task automatic check_array(input int blk, input int cnt, input string tag);
    logic [7:0] v;
    wr(0, 8'hFF);
    for (int k = 0; k < cnt; k++) begin
      int a = blk*256 + $urandom_range(0, 255);
      rd(a, v);
      chk({tag, " array contents"}, v, m[a]);
    end
  endtask

  task automatic clear_stat();
    logic [7:0] v;
    wr(0, 8'h50);
    es = 0; ps = 0; bs = 0;
    wr(0, 8'h70);
    rd(0, v);
    chk("R13 status cleared by 50h", v, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R7 got=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    wp = 1'b0; ovr = 1'b0;
    for (int i = 0; i < 1024; i++) m[i] = 8'hFF;
    for (int b = 0; b < 4; b++) lk[b] = 1;
    es = 0; ps = 0; bs = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy low in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy low after reset", busy, 0);
    rd(37, v);
    chk("R1 array reads erased in default mode", v, 8'hFF);
    wr(0, 8'h71);
    rd(600, v);
    chk("R1 R11 lock bit unlocked after reset", v, 8'h40);
    wr(0, 8'h70);
    rd(0, v);
    chk("R1 R4 status after reset", v, 8'h80);

    // R2 R3 identifier and mode switching
    wr(0, 8'h90);
    rd(0, v);
    chk("R3 maker code", v, 8'h07);
    rd(1, v);
    chk("R3 device code", v, 8'h85);
    rd(513, v);
    chk("R3 device code upper address ignored", v, 8'h85);
    wr(0, 8'hFF);
    rd(2, v);
    chk("R2 back to array mode", v, 8'hFF);
    @(negedge clk);
    chk("R2 rdata holds without strobe", rdata, 8'hFF);

    // R5 confirm sequence error
    wr(0, 8'h20);
    wr(0, 8'h33);
    es = 1; ps = 1;
    chk("R5 no operation after bad confirm", busy, 0);
    rd(0, v);
    chk("R5 sequence error status", v, stat_exp(1, 0));
    clear_stat();
    wr(0, 8'hA7);
    wr(0, 8'hFF);
    es = 1; ps = 1;
    chk("R5 erase-all not started", busy, 0);
    rd(0, v);
    chk("R5 erase-all sequence error status", v, stat_exp(1, 0));
    clear_stat();

    // R6 R7 R14 random traffic
    for (int it = 0; it < 10; it++) begin
      int blk = $urandom_range(0, 3);
      int kind = $urandom_range(0, 3);
      if (kind == 3) erase_blk(blk, "random");
      else prog_page(blk, $urandom_range(0, 1), "random R6");
      check_array(blk, 4, "R6 random");
      if (bs || es || ps) begin
        wr(0, 8'h70);
        clear_stat();
      end
    end

    // R14 forced over-program: program same page twice with fresh data
    erase_blk(2, "R14 prep");
    prog_page(2, 1, "R14 first");
    prog_page(2, 1, "R14 second");
    check_array(2, 4, "R14");
    wr(0, 8'h70);
    clear_stat();

    // R6 out-of-order page word
    wr(0, 8'h41);
    wr(0, 8'h00);
    wr(5, 8'h00);
    es = 1; ps = 1;
    chk("R6 out-of-order not started", busy, 0);
    rd(0, v);
    chk("R6 out-of-order status", v, stat_exp(1, 0));
    check_array(0, 3, "R6 out-of-order left array");
    wr(0, 8'h70);

    // R8 writes ignored while busy, sticky errors kept
    load_page(1, 0);
    wr(0, 8'h50);
    wr(0, 8'hFF);
    rd(100, v);
    chk("R8 busy read returns status", v, stat_exp(0, 0));
    busy_len(n);
    chk("R8 busy length unaffected", n, PCYC - 3);
    apply_page(1, 0);
    rd(100, v);
    chk("R8 R13 errors kept and mode unchanged", v, stat_exp(1, 0));
    clear_stat();
    check_array(1, 4, "R8");

    // R9 suspend and resume of an erase
    wr(0, 8'h20);
    wr(256, 8'hD0);
    repeat (3) @(negedge clk);
    wr(0, 8'hB0);
    chk("R9 busy falls on suspend", busy, 0);
    rd(0, v);
    chk("R9 suspended status", v, stat_exp(1, 1));
    wr(0, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      int a = $urandom_range(0, 255);
      rd(a, v);
      chk("R9 array read while suspended", v, m[a]);
    end
    wr(0, 8'hD0);
    chk("R9 busy back after resume", busy, 1);
    busy_len(n);
    chk("R9 R7 remaining erase length", n, ECYC - 4);
    for (int j = 0; j < 256; j++) m[256 + j] = 8'hFF;
    wr(0, 8'h70);
    rd(0, v);
    chk("R9 suspend bit cleared", v, stat_exp(1, 0));
    check_array(1, 4, "R9 erased block");

    // R10 R11 lock protection
    prog_page(3, 0, "R12 prep");
    wr(0, 8'h71);
    rd(2*256, v);
    chk("R11 block 2 unlocked", v, 8'h40);
    lock_blk(2);
    wr(0, 8'h71);
    rd(2*256 + 77, v);
    chk("R11 block 2 locked", v, 8'h00);
    rd(1*256, v);
    chk("R11 block 1 still unlocked", v, 8'h40);
    erase_blk(2, "R10 locked");
    check_array(2, 4, "R10 locked erase");
    wr(0, 8'h70);
    clear_stat();
    prog_page(2, 0, "R10 locked");
    check_array(2, 4, "R10 locked program");
    wr(0, 8'h70);
    clear_stat();
    wp = 1'b1;
    erase_blk(2, "R10 released by protect input");
    wp = 1'b0;
    wr(0, 8'h71);
    rd(2*256, v);
    chk("R10 erase restores lock bit", v, 8'h40);
    check_array(2, 4, "R10 released erase");
    lock_blk(0);
    ovr = 1'b1;
    prog_page(0, 1, "R10 override");
    ovr = 1'b0;
    check_array(0, 4, "R10 override program");
    wr(0, 8'h70);
    if (bs) clear_stat();

    // R12 erase all with blocks 0 and 3 locked
    lock_blk(3);
    wr(0, 8'hA7);
    wr(0, 8'hD0);
    busy_len(n);
    chk("R12 R7 erase-all busy length", n, ECYC);
    for (int b = 0; b < 4; b++)
      if (lk[b]) for (int j = 0; j < 256; j++) m[b*256 + j] = 8'hFF;
    rd(0, v);
    chk("R12 status after erase-all", v, stat_exp(1, 0));
    for (int b = 0; b < 4; b++) check_array(b, 4, "R12");
    wr(0, 8'h71);
    rd(3*256, v);
    chk("R12 locked block keeps lock bit", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule